// File: doc/BRIEF.md
# External Memory Bus Timing Sequencer

This block sits between an internal host port and an external parallel memory bus. It takes one single-beat read or write at a time over a valid/ready handshake and plays it out on the bus as a timed sequence of chip select, address strobe, output enable, write enable, address and data activity. All external strobes are active low and come from flops, and at most one chip select is low at any time.

Each chip select has its own timing word, which arrives on a flat configuration input. The word sets the wait cycles for reads and for writes, the first-access latency for reads and for writes on page or burst memories, the write hold, the gap between the address cycle and output enable, and whether the address is held one cycle after the address strobe. The controller records the type and target of the last access, so it can insert turnaround cycles where a read would otherwise collide with the next bus driver. It also keeps a page flag and page address for each chip select, so it charges the first-access latency only when an access opens a new page.

States: IDLE (waiting; accepts a request), RECOV (turnaround gap, all strobes inactive), ADDR (address cycle with the address strobe low), LEAD (read only; gap before output enable), ACT (output enable or write enable low), WHOLD (write only; chip select held with data driven), DONE (one cycle, ready high, bus released). Transitions: IDLE→RECOV or IDLE→ADDR on a request; RECOV→ADDR when the gap ends; ADDR→LEAD for a read with a nonzero lead, otherwise ADDR→ACT; LEAD→ACT; ACT→WHOLD for a write or ACT→DONE for a read; WHOLD→DONE; DONE→IDLE.

Top module: `ext_bus_seq`

## Requirements
- R1: While reset is held, every chip select, the address strobe, output enable and write enable are high, the data drive enable and ready are low, and the address pins are zero.
- R2: An accepted request to chip select c drives only chip select c low. Its first cycle is the address cycle, in which the address strobe is low for exactly one cycle and the request address is on the address pins.
- R3: In the cycle after the address cycle, the address pins still carry the address if the chip's address-hold bit (timing word bit 38) is 1, and read zero if it is 0. Whenever no chip select is low, the address pins read zero.
- R4: For a read, output enable first goes low 1 + max(read-hold, strobe-to-OE) cycles after the address cycle. The read-hold field is timing word bits 35:32 and the strobe-to-OE field is bits 37:36.
- R5: For a read, output enable stays low for 1 + L + read-wait cycles. Read-wait is bits 3:0, and L is the first-access latency from R8. The value on the data input pins in the last output-enable cycle is returned on the read data port in the following cycle, when ready is high and every chip select is high.
- R6: For a write, write enable is low for 1 + L + write-wait cycles (write-wait is bits 7:4), starting in the cycle after the address cycle. The chip select then stays low for max(1, write-hold) more cycles (write-hold is bits 31:28). Write data is driven, with the drive enable high, from the first write-enable cycle until the chip select releases, and ready is high in the cycle after that.
- R7: If the previous access was a read, and the new access targets another chip select or is a write, max(1, R) cycles with all strobes inactive come before the new address cycle. R is bits 27:24 of the previous chip select's timing word. Otherwise the address cycle follows acceptance directly.
- R8: L is the first-access latency: bits 15:8 for reads and bits 23:16 for writes. It applies when the chip's page flag is clear, or when the stored page differs from address bits above PAGE_OFS; otherwise L is 0. Each access sets its own chip's flag and page and clears the flags of all other chip selects. Reset clears every flag.
- R9: A request is taken only in IDLE, on the clock edge where valid is high, and the bus outputs change at that edge. Ready is a single-cycle pulse. After ready there is one idle cycle before the next request can be taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_valid | input | 1 | Request present; held with its fields until ready |
| host_ready | output | 1 | One-cycle pulse ending the access |
| host_cs | input | CS_W | Target chip select index |
| host_addr | input | ADDR_W | Access address |
| host_we | input | 1 | 1 for write, 0 for read |
| host_wdata | input | DATA_W | Write data |
| host_rdata | output | DATA_W | Read data, valid with ready |
| cfg_i | input | NCS*CFG_W | Timing words, chip select k at bits k*CFG_W and up |
| bus_cs_n | output | NCS | Chip selects, active low |
| bus_adv_n | output | 1 | Address strobe, active low |
| bus_oe_n | output | 1 | Output enable, active low |
| bus_we_n | output | 1 | Write enable, active low |
| bus_addr | output | ADDR_W | Address pins |
| bus_dout | output | DATA_W | Data driven to memory |
| bus_dout_en | output | 1 | Data drive enable |
| bus_din | input | DATA_W | Data from memory |

## Verification
The bench aims at the turnaround rule. It covers read followed by read on the same chip (a design that inserts a gap here stretches the access), read followed by a write on the same chip, and a switch from a read on one chip to another chip. A design that reads the gap length from the wrong chip's word, or forgets the floor of one, shifts the address cycle. Page tracking is tested by revisiting a page after a neighbouring chip has cleared its flag, and with a 255-cycle latency. An off-by-one in the lead, wait or hold counts moves the edges of output enable, write enable or ready, and the bench catches that by recording the cycle index of every edge.

// File: rtl/ebs_pkg.sv
package ebs_pkg;

    localparam int CFG_W = 39;   // bits per chip-select timing word
    localparam int CNT_W = 9;    // holds latency (255) + wait (15)

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RECOV,
        ST_ADDR,
        ST_LEAD,
        ST_ACT,
        ST_WHOLD,
        ST_DONE
    } ebs_state_e;

    typedef struct packed {
        logic       addr_hold;
        logic [1:0] adv_oe;
        logic [3:0] rd_hold;
        logic [3:0] wr_hold;
        logic [7:0] wr_lat;
        logic [7:0] rd_lat;
        logic [3:0] wr_wait;
        logic [3:0] rd_wait;
    } ebs_timing_t;

endpackage

// File: rtl/ebs_cfg_pick.sv
module ebs_cfg_pick
    import ebs_pkg::*;
#(
    parameter int NCS  = 2,
    parameter int CS_W = 1
) (
    input  logic [NCS*CFG_W-1:0] cfg_i,
    input  logic [CS_W-1:0]      req_sel_i,
    input  logic [CS_W-1:0]      last_sel_i,
    output ebs_timing_t          tim_o,
    output logic [3:0]           rec_o
);

    logic [CFG_W-1:0] raw [NCS];
    logic [CFG_W-1:0] sel;

    for (genvar g = 0; g < NCS; g++) begin : g_slice
        assign raw[g] = cfg_i[g*CFG_W +: CFG_W];
    end

    always_comb begin
        sel             = raw[req_sel_i];
        tim_o.rd_wait   = sel[3:0];
        tim_o.wr_wait   = sel[7:4];
        tim_o.rd_lat    = sel[15:8];
        tim_o.wr_lat    = sel[23:16];
        tim_o.wr_hold   = sel[31:28];
        tim_o.rd_hold   = sel[35:32];
        tim_o.adv_oe    = sel[37:36];
        tim_o.addr_hold = sel[38];
        rec_o           = raw[last_sel_i][27:24];
    end

endmodule

// File: rtl/ebs_page_track.sv
module ebs_page_track #(
    parameter int NCS  = 2,
    parameter int CS_W = 1,
    parameter int PG_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            upd_i,
    input  logic [CS_W-1:0] cs_i,
    input  logic [PG_W-1:0] page_i,
    output logic            first_o
);

    logic [NCS-1:0]  open_v;
    logic [PG_W-1:0] page_v [NCS];

    for (genvar g = 0; g < NCS; g++) begin : g_cs
        logic            op_q;
        logic [PG_W-1:0] pg_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                op_q <= 1'b0;
                pg_q <= '0;
            end else if (upd_i) begin
                if (cs_i == CS_W'(g)) begin
                    op_q <= 1'b1;
                    pg_q <= page_i;
                end else begin
                    op_q <= 1'b0;
                end
            end
        end
        assign open_v[g] = op_q;
        assign page_v[g] = pg_q;
    end

    assign first_o = !open_v[cs_i] || (page_v[cs_i] != page_i);

endmodule

// File: rtl/ebs_turnaround.sv
module ebs_turnaround #(
    parameter int CS_W = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            acc_i,
    input  logic [CS_W-1:0] cs_i,
    input  logic            we_i,
    output logic            need_o,
    output logic [CS_W-1:0] last_cs_o
);

    logic            vld_q;
    logic            rd_q;
    logic [CS_W-1:0] cs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            rd_q  <= 1'b0;
            cs_q  <= '0;
        end else if (acc_i) begin
            vld_q <= 1'b1;
            rd_q  <= !we_i;
            cs_q  <= cs_i;
        end
    end

    assign need_o    = vld_q && rd_q && ((cs_i != cs_q) || we_i);
    assign last_cs_o = cs_q;

endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
    import ebs_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 16,
    parameter int NCS      = 2,
    parameter int PAGE_OFS = 4,
    localparam int CS_W    = $clog2(NCS),
    localparam int PG_W    = ADDR_W - PAGE_OFS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  host_valid,
    output logic                  host_ready,
    input  logic [CS_W-1:0]       host_cs,
    input  logic [ADDR_W-1:0]     host_addr,
    input  logic                  host_we,
    input  logic [DATA_W-1:0]     host_wdata,
    output logic [DATA_W-1:0]     host_rdata,
    input  logic [NCS*CFG_W-1:0]  cfg_i,
    output logic [NCS-1:0]        bus_cs_n,
    output logic                  bus_adv_n,
    output logic                  bus_oe_n,
    output logic                  bus_we_n,
    output logic [ADDR_W-1:0]     bus_addr,
    output logic [DATA_W-1:0]     bus_dout,
    output logic                  bus_dout_en,
    input  logic [DATA_W-1:0]     bus_din
);

    ebs_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;

    logic [CS_W-1:0]   req_cs_q;
    logic [ADDR_W-1:0] req_addr_q;
    logic              req_we_q;
    logic [DATA_W-1:0] req_wdata_q;
    logic              req_first_q;

    ebs_timing_t       tim;
    logic [3:0]        rec_raw, rec_len, lead, hold_len;
    logic [CNT_W-1:0]  lw;
    logic              accept, need_rec, first_new, drive;
    logic [CS_W-1:0]   last_cs, cs_nxt;
    logic [ADDR_W-1:0] addr_nxt;

    assign accept   = (state_q == ST_IDLE) && host_valid;
    assign cs_nxt   = accept ? host_cs : req_cs_q;
    assign addr_nxt = accept ? host_addr : req_addr_q;

    ebs_cfg_pick #(.NCS(NCS), .CS_W(CS_W)) u_pick (
        .cfg_i      (cfg_i),
        .req_sel_i  (req_cs_q),
        .last_sel_i (last_cs),
        .tim_o      (tim),
        .rec_o      (rec_raw)
    );

    ebs_turnaround #(.CS_W(CS_W)) u_turn (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_i     (accept),
        .cs_i      (host_cs),
        .we_i      (host_we),
        .need_o    (need_rec),
        .last_cs_o (last_cs)
    );

    ebs_page_track #(.NCS(NCS), .CS_W(CS_W), .PG_W(PG_W)) u_page (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd_i   (accept),
        .cs_i    (host_cs),
        .page_i  (host_addr[ADDR_W-1:PAGE_OFS]),
        .first_o (first_new)
    );

    // derived cycle counts
    always_comb begin
        rec_len  = (rec_raw == 4'd0) ? 4'd1 : rec_raw;
        hold_len = (tim.wr_hold == 4'd0) ? 4'd1 : tim.wr_hold;
        lead     = (tim.rd_hold > {2'b00, tim.adv_oe}) ? tim.rd_hold : {2'b00, tim.adv_oe};
        lw       = CNT_W'(req_first_q ? (req_we_q ? tim.wr_lat : tim.rd_lat) : 8'd0)
                 + CNT_W'(req_we_q ? tim.wr_wait : tim.rd_wait);
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (host_valid) begin
                    if (need_rec) begin
                        state_d = ST_RECOV;
                        cnt_d   = CNT_W'(rec_len) - 1'b1;
                    end else begin
                        state_d = ST_ADDR;
                    end
                end
            end
            ST_RECOV: begin
                if (cnt_q == '0) state_d = ST_ADDR;
                else             cnt_d   = cnt_q - 1'b1;
            end
            ST_ADDR: begin
                if (req_we_q || lead == 4'd0) begin
                    state_d = ST_ACT;
                    cnt_d   = lw;
                end else begin
                    state_d = ST_LEAD;
                    cnt_d   = CNT_W'(lead) - 1'b1;
                end
            end
            ST_LEAD: begin
                if (cnt_q == '0) begin
                    state_d = ST_ACT;
                    cnt_d   = lw;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_ACT: begin
                if (cnt_q == '0) begin
                    if (req_we_q) begin
                        state_d = ST_WHOLD;
                        cnt_d   = CNT_W'(hold_len) - 1'b1;
                    end else begin
                        state_d = ST_DONE;
                    end
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_WHOLD: begin
                if (cnt_q == '0) state_d = ST_DONE;
                else             cnt_d   = cnt_q - 1'b1;
            end
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register, request capture, read capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            cnt_q       <= '0;
            req_cs_q    <= '0;
            req_addr_q  <= '0;
            req_we_q    <= 1'b0;
            req_wdata_q <= '0;
            req_first_q <= 1'b0;
            host_rdata  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (accept) begin
                req_cs_q    <= host_cs;
                req_addr_q  <= host_addr;
                req_we_q    <= host_we;
                req_wdata_q <= host_wdata;
                req_first_q <= first_new;
            end
            if (state_q == ST_ACT && cnt_q == '0 && !req_we_q)
                host_rdata <= bus_din;
        end
    end

    assign drive = (state_d == ST_ADDR) || (state_d == ST_LEAD) ||
                   (state_d == ST_ACT)  || (state_d == ST_WHOLD);

    // registered outputs decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_cs_n    <= '1;
            bus_adv_n   <= 1'b1;
            bus_oe_n    <= 1'b1;
            bus_we_n    <= 1'b1;
            bus_addr    <= '0;
            bus_dout    <= '0;
            bus_dout_en <= 1'b0;
            host_ready  <= 1'b0;
        end else begin
            bus_cs_n    <= drive ? ~(NCS'(1) << cs_nxt) : '1;
            bus_adv_n   <= !(state_d == ST_ADDR);
            bus_oe_n    <= !(state_d == ST_ACT && !req_we_q);
            bus_we_n    <= !(state_d == ST_ACT && req_we_q);
            if (state_d == ST_ADDR)
                bus_addr <= addr_nxt;
            else if (state_q == ST_ADDR && tim.addr_hold)
                bus_addr <= req_addr_q;
            else
                bus_addr <= '0;
            bus_dout_en <= req_we_q && (state_d == ST_ACT || state_d == ST_WHOLD);
            bus_dout    <= (req_we_q && (state_d == ST_ACT || state_d == ST_WHOLD))
                           ? req_wdata_q : '0;
            host_ready  <= (state_d == ST_DONE);
        end
    end

endmodule

// File: rtl/ebs_checker.sv
module ebs_checker #(
    parameter int ADDR_W = 16,
    parameter int NCS    = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_ready,
    input logic [NCS-1:0]    bus_cs_n,
    input logic              bus_adv_n,
    input logic              bus_oe_n,
    input logic              bus_we_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_dout_en
);

    AST_ONE_CS: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~bus_cs_n)); // R2

    AST_ADV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_adv_n |=> bus_adv_n); // R2

    AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_adv_n || !bus_oe_n || !bus_we_n) |-> !(&bus_cs_n)); // R2

    AST_ADDR_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (&bus_cs_n) |-> (bus_addr == '0)); // R3

    AST_OE_WE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_oe_n && !bus_we_n)); // R5

    AST_READY_BUS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |-> ((&bus_cs_n) && !bus_dout_en)); // R5

    AST_WE_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we_n |-> bus_dout_en); // R6

    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |=> !host_ready); // R9

endmodule

bind ext_bus_seq ebs_checker #(.ADDR_W(ADDR_W), .NCS(NCS)) u_ebs_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_ready  (host_ready),
    .bus_cs_n    (bus_cs_n),
    .bus_adv_n   (bus_adv_n),
    .bus_oe_n    (bus_oe_n),
    .bus_we_n    (bus_we_n),
    .bus_addr    (bus_addr),
    .bus_dout_en (bus_dout_en)
);

// File: tb/tb_ext_bus_seq.sv
module tb_ext_bus_seq;
    localparam int ADDR_W = 16, DATA_W = 16, NCS = 2, PAGE_OFS = 4;
    localparam int CS_W = 1, CFG_W = 39;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic                 host_valid = 1'b0, host_we = 1'b0;
    logic                 host_ready;
    logic [CS_W-1:0]      host_cs = '0;
    logic [ADDR_W-1:0]    host_addr = '0;
    logic [DATA_W-1:0]    host_wdata = '0, host_rdata;
    logic [NCS*CFG_W-1:0] cfg = '0;
    logic [NCS-1:0]       bus_cs_n;
    logic                 bus_adv_n, bus_oe_n, bus_we_n, bus_dout_en;
    logic [ADDR_W-1:0]    bus_addr;
    logic [DATA_W-1:0]    bus_dout, bus_din = '0;

    ext_bus_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NCS(NCS), .PAGE_OFS(PAGE_OFS)) dut (
        .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_ready(host_ready),
        .host_cs(host_cs), .host_addr(host_addr), .host_we(host_we),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .cfg_i(cfg),
        .bus_cs_n(bus_cs_n), .bus_adv_n(bus_adv_n), .bus_oe_n(bus_oe_n),
        .bus_we_n(bus_we_n), .bus_addr(bus_addr), .bus_dout(bus_dout),
        .bus_dout_en(bus_dout_en), .bus_din(bus_din)
    );

    int n_chk = 0, n_fail = 0;
    int rdw[NCS], wrw[NCS], rdl[NCS], wrl[NCS], rec[NCS], wh[NCS], rh[NCS], ao[NCS], ah[NCS];
    bit m_vld = 0, m_rd = 0;
    int m_cs = 0;
    bit m_open[NCS];
    int m_page[NCS];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int max1(input int x);
        return (x < 1) ? 1 : x;
    endfunction

    function automatic int maxi(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    task automatic set_cfg();
        for (int k = 0; k < NCS; k++)
            cfg[k*CFG_W +: CFG_W] = {1'(ah[k]), 2'(ao[k]), 4'(rh[k]), 4'(wh[k]), 4'(rec[k]),
                                     8'(wrl[k]), 8'(rdl[k]), 4'(wrw[k]), 4'(rdw[k])};
    endtask

    task automatic do_access(input int cs, input int addr, input bit we, input int wd);
        int rn, s, l, w, h, pg, idx, rdy_idx;
        int cs_first, cs_cnt, adv_cnt, adv_idx, oe_first, oe_cnt, we_first, we_cnt;
        int den_cnt, bad_cs, bad_dout, rec_strobe, a0, a1;
        bit first;
        logic [DATA_W-1:0] din_v, rd;
        pg = addr >> PAGE_OFS;
        rn = (m_vld && m_rd && (cs != m_cs || we)) ? max1(rec[m_cs]) : 0;
        first = !m_open[cs] || (m_page[cs] != pg);
        l = first ? (we ? wrl[cs] : rdl[cs]) : 0;
        w = we ? wrw[cs] : rdw[cs];
        s = maxi(rh[cs], ao[cs]);
        h = max1(wh[cs]);
        for (int k = 0; k < NCS; k++) m_open[k] = 0;
        m_open[cs] = 1; m_page[cs] = pg;
        m_vld = 1; m_rd = !we; m_cs = cs;

        din_v = DATA_W'(addr * 7 + 13);
        bus_din = din_v;
        host_cs = CS_W'(cs); host_addr = ADDR_W'(addr); host_we = we;
        host_wdata = DATA_W'(wd); host_valid = 1'b1;
        cs_first = -1; oe_first = -1; we_first = -1; adv_idx = -1; rdy_idx = -1;
        cs_cnt = 0; adv_cnt = 0; oe_cnt = 0; we_cnt = 0; den_cnt = 0;
        bad_cs = 0; bad_dout = 0; rec_strobe = 0; a0 = -1; a1 = -1; rd = '0;
        idx = 0;
        while (rdy_idx < 0 && idx < 1000) begin
            @(posedge clk); @(negedge clk);
            if (bus_cs_n != '1) begin
                if (cs_first < 0) cs_first = idx;
                cs_cnt++;
                if (bus_cs_n != ~(NCS'(1) << cs)) bad_cs++;
            end
            if (!bus_adv_n) begin adv_cnt++; adv_idx = idx; end
            if (!bus_oe_n) begin if (oe_first < 0) oe_first = idx; oe_cnt++; end
            if (!bus_we_n) begin if (we_first < 0) we_first = idx; we_cnt++; end
            if (bus_dout_en) begin den_cnt++; if (bus_dout != DATA_W'(wd)) bad_dout++; end
            if (idx == rn) a0 = int'(bus_addr);
            if (idx == rn + 1) a1 = int'(bus_addr);
            if (idx < rn && (bus_cs_n != '1 || !bus_adv_n || !bus_oe_n || !bus_we_n)) rec_strobe++;
            if (host_ready) begin rdy_idx = idx; rd = host_rdata; end
            idx++;
        end
        host_valid = 1'b0;

        check(cs_first == rn, "R7 address cycle position", cs_first, rn);
        check(rec_strobe == 0, "R7 strobes idle in gap", rec_strobe, 0);
        check(adv_cnt == 1 && adv_idx == rn, "R2 address strobe", adv_idx, rn);
        check(bad_cs == 0, "R2 chip select choice", bad_cs, 0);
        check(a0 == (addr & 16'hFFFF), "R2 address in address cycle", a0, addr);
        check(a1 == (ah[cs] != 0 ? (addr & 16'hFFFF) : 0), "R3 address hold", a1,
              ah[cs] != 0 ? addr : 0);
        if (!we) begin
            check(oe_first == rn + 1 + s, "R4 OE start", oe_first, rn + 1 + s);
            check(oe_cnt == 1 + l + w, first ? "R8 read length with latency" : "R5 read length",
                  oe_cnt, 1 + l + w);
            check(we_cnt == 0 && den_cnt == 0, "R5 no write strobes", we_cnt + den_cnt, 0);
            check(rd == din_v, "R5 read data", int'(rd), int'(din_v));
            check(rdy_idx == rn + 2 + s + l + w, "R5 ready timing", rdy_idx, rn + 2 + s + l + w);
        end else begin
            check(we_first == rn + 1, "R6 WE start", we_first, rn + 1);
            check(we_cnt == 1 + l + w, first ? "R8 write length with latency" : "R6 write length",
                  we_cnt, 1 + l + w);
            check(cs_cnt == 2 + l + w + h, "R6 chip select span with hold", cs_cnt, 2 + l + w + h);
            check(den_cnt == 1 + l + w + h, "R6 data drive span", den_cnt, 1 + l + w + h);
            check(bad_dout == 0, "R6 write data value", bad_dout, 0);
            check(oe_cnt == 0, "R6 no OE on write", oe_cnt, 0);
            check(rdy_idx == rn + 2 + l + w + h, "R6 ready timing", rdy_idx, rn + 2 + l + w + h);
        end
        // the idle cycle after ready (R9)
        @(posedge clk); @(negedge clk);
        check(!host_ready && bus_cs_n == '1, "R9 idle after ready", int'(host_ready), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd7321));
        for (int k = 0; k < NCS; k++) begin m_open[k] = 0; m_page[k] = 0; end
        rdw[0] = 2; wrw[0] = 1; rdl[0] = 3; wrl[0] = 5; rec[0] = 0; wh[0] = 0; rh[0] = 2; ao[0] = 1; ah[0] = 1;
        rdw[1] = 0; wrw[1] = 3; rdl[1] = 0; wrl[1] = 2; rec[1] = 4; wh[1] = 3; rh[1] = 0; ao[1] = 3; ah[1] = 0;
        set_cfg();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(bus_cs_n == '1 && bus_adv_n && bus_oe_n && bus_we_n && !bus_dout_en
              && !host_ready && bus_addr == '0, "R1 reset state", int'(bus_cs_n), 3);
        rst_n = 1'b1;
        @(negedge clk);

        do_access(0, 16'h0120, 0, 0);        // first read: latency, no gap
        do_access(0, 16'h0124, 0, 0);        // same page, read after read same chip: no gap
        do_access(0, 16'h0128, 1, 16'hBEEF); // read then write same chip: zero field gives 1
        do_access(0, 16'h0300, 1, 16'h1234); // write then write: no gap, new page
        do_access(1, 16'h0050, 0, 0);        // after write: no gap
        do_access(0, 16'h0300, 0, 0);        // chip switch after read: gap from chip 1, flag cleared
        do_access(1, 16'h0050, 0, 0);        // chip switch: floor of one
        do_access(1, 16'h0051, 1, 16'h00FF); // read then write same chip: gap 4, page hit
        wrl[1] = 255; set_cfg();
        do_access(1, 16'h0900, 1, 16'hA5A5); // maximum first-access latency

        for (int n = 0; n < 80; n++) begin
            if (n % 10 == 0) begin
                for (int k = 0; k < NCS; k++) begin
                    rdw[k] = $urandom_range(15); wrw[k] = $urandom_range(15);
                    rdl[k] = $urandom_range(6);  wrl[k] = $urandom_range(6);
                    rec[k] = $urandom_range(15); wh[k]  = $urandom_range(15);
                    rh[k]  = $urandom_range(15); ao[k]  = $urandom_range(3);
                    ah[k]  = $urandom_range(1);
                end
                set_cfg();
            end
            do_access($urandom_range(NCS - 1), ($urandom_range(3) << PAGE_OFS) | $urandom_range(15),
                      $urandom_range(1) == 1, $urandom_range(16'hFFFF));
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule